// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block lets a host processor program a bank of configuration words over a four-wire serial link (active-low select, serial clock, data in, data out). The serial pins are asynchronous to the block: they are oversampled by a fast system clock, so that clock must run several times faster than the serial clock. A transaction carries a 7-bit register address, a direction flag and one 16-bit data word. The register contents are presented in parallel to the rest of the chip.

Each register has its own width and reset value. Bits above a register's width do not exist, and addresses with no register behind them read as zero.

A second, parallel access port in the system clock domain gives another agent write and read access to the same bank. Its reads are only enabled while a control bit in register 0x00 is set.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset the registers hold: 0x00 = 0x0004, 0x01 = 0x282B, 0x0C and 0x12 = 0x00ED, 0x0D and 0x0F = 0x0825, 0x0E = 0xF43A, 0x10 = 0xCEFF, 0x11 = 0x1613, 0x13 and 0x15 = 0x1DAA, 0x14 = 0xCBEF, 0x16 = 0xC7F6, 0x17 = 0x1F4D, 0x1A = 0x05C6; every other register holds zero. The serial output is low.
- R2: A frame is 24 serial clock periods while select is low. SDI is sampled on each falling SCLK edge, MSB first, in this order: address bits 6..0, then the direction bit (1 = read, 0 = write), then data bits 15..0.
- R3: A write frame updates the addressed register only after the 24th falling edge. Data bits above the register's width are dropped. Widths: 0x00 is 14 bits, 0x0C and 0x12 are 9 bits, 0x1A is 12 bits, and 0x01 and 0x0D–0x11, 0x13–0x17 are 16 bits.
- R4: In a read frame the block drives the addressed register's 16 bits on SDO, MSB first. Each bit is updated after a rising SCLK edge so the host can sample it on the falling edges 9 to 24. SDO is low while select is high.
- R5: Addresses with no register read as 0x0000 and ignore writes. This covers 0x02–0x0B, 0x18, 0x19, 0x1B–0x1F and every address from 0x20 up.
- R6: If select rises before the 24th falling edge, the frame is discarded and no register changes.
- R7: The parallel port writes the addressed register (masked to its width) on the clock edge where its write enable is high. Its read data shows the addressed register only while bit 12 of register 0x00 is 1; otherwise it reads zero.
- R8: When a serial write commits in the same cycle as a parallel write, the serial write takes effect and the parallel write is dropped.
- R9: The parallel output carries register n in bits [16n+15:16n] for n = 0..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| ind_we | input | 1 | Parallel port write enable |
| ind_addr | input | 7 | Parallel port register address |
| ind_wdata | input | 16 | Parallel port write data |
| ind_rdata | output | 16 | Parallel port read data |
| cfg_regs | output | 512 | All register contents, 16 bits per register |

## Verification
The assertions check several rules on every cycle. A serial or parallel write lands masked in the addressed register, and the losing parallel write leaves its target untouched. While select is high, SDO stays low and no write strobe appears. A commit only happens with a full bit count. Other behaviour can only be shown by the bench's scenarios at the pins: that the bit order and direction flag decode as specified, that a read returns the right word MSB first, that truncated frames and unimplemented addresses leave the bank unchanged, that the reset values are correct, and that the parallel read gate follows register 0x00.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   localparam int WORD_W      = 16;
   localparam int ADR_W       = 7;
   localparam int IND_RD_BIT  = 12;   // bit of register 0 gating parallel reads

   typedef struct packed {
      logic              en;
      logic [ADR_W-1:0]  addr;
      logic [WORD_W-1:0] data;
   } wr_req_t;

   // implemented bits of each register
   function automatic logic [WORD_W-1:0] reg_mask(input int idx);
      case (idx)
         'h00:                        return 16'h3FFF;
         'h0C, 'h12:                  return 16'h01FF;
         'h1A:                        return 16'h0FFF;
         'h01, 'h0D, 'h0E, 'h0F, 'h10, 'h11,
         'h13, 'h14, 'h15, 'h16, 'h17: return 16'hFFFF;
         default:                     return 16'h0000;
      endcase
   endfunction

   function automatic logic [WORD_W-1:0] reg_init(input int idx);
      case (idx)
         'h00:       return 16'h0004;
         'h01:       return 16'h282B;
         'h0C, 'h12: return 16'h00ED;
         'h0D, 'h0F: return 16'h0825;
         'h0E:       return 16'hF43A;
         'h10:       return 16'hCEFF;
         'h11:       return 16'h1613;
         'h13, 'h15: return 16'h1DAA;
         'h14:       return 16'hCBEF;
         'h16:       return 16'hC7F6;
         'h17:       return 16'h1F4D;
         'h1A:       return 16'h05C6;
         default:    return 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int HIST = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync needs at least two synchronizer stages");
   end

   logic [HIST-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {HIST{RESET_VAL}};
      else        chain_q <= {chain_q[HIST-2:0], pin_i};
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sck_rise_i,
   input  logic              sck_fall_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              sdo_o
);
   localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] C_DIR  = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] C_DAT  = CNT_W'(ADDR_W + 1);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_BITS);

   if (DATA_W < ADDR_W) begin : g_bad_width
      $error("spi_frame_engine: data word narrower than address");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] rx_q, tx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         addr_q    <= '0;
         rd_q      <= 1'b0;
         sdo_o     <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (!sel_i) begin
            cnt_q <= '0;
            rd_q  <= 1'b0;
            sdo_o <= 1'b0;
         end else begin
            if (sck_fall_i && cnt_q < C_FULL) begin
               rx_q  <= {rx_q[DATA_W-2:0], sdi_i};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == C_DIR) begin
                  addr_q <= rx_q[ADDR_W-1:0];
                  rd_q   <= sdi_i;
                  tx_q   <= rd_data_i;
               end
               if (cnt_q == C_LAST && !rd_q) begin
                  wr_en_o   <= 1'b1;
                  wr_data_o <= {rx_q[DATA_W-2:0], sdi_i};
               end
            end
            if (sck_rise_i && rd_q && cnt_q >= C_DAT && cnt_q <= C_LAST) begin
               sdo_o <= tx_q[DATA_W-1];
               tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rd_addr_o = rx_q[ADDR_W-1:0];
   assign wr_addr_o = addr_q;

   // R6
   no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> !wr_en_o);
   // R4
   sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> !sdo_o);
   // R2
   full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> cnt_q == C_FULL);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import spi_cfg_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  wr_req_t                    spi_wr_i,
   input  logic [ADDR_W-1:0]          spi_raddr_i,
   output logic [DATA_W-1:0]          spi_rdata_o,
   input  wr_req_t                    ind_wr_i,
   input  logic [ADDR_W-1:0]          ind_raddr_i,
   output logic [DATA_W-1:0]          ind_rdata_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("cfg_reg_bank: more registers than addresses");
   end

   logic [DATA_W-1:0] q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = reg_mask(i);
      localparam logic [DATA_W-1:0] INIT = reg_init(i);
      logic spi_hit, ind_hit;
      assign spi_hit = spi_wr_i.en && spi_wr_i.addr == ADDR_W'(i);
      assign ind_hit = ind_wr_i.en && !spi_wr_i.en && ind_wr_i.addr == ADDR_W'(i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[i] <= INIT;
         else if (spi_hit) q[i] <= spi_wr_i.data & MASK;
         else if (ind_hit) q[i] <= ind_wr_i.data & MASK;
      end

      assign regs_o[i*DATA_W +: DATA_W] = q[i];

      // R3
      spi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (spi_wr_i.en && spi_wr_i.addr == ADDR_W'(i))
            |=> q[i] == ($past(spi_wr_i.data) & MASK));
      // R7
      ind_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ind_wr_i.en && !spi_wr_i.en && ind_wr_i.addr == ADDR_W'(i))
            |=> q[i] == ($past(ind_wr_i.data) & MASK));
      // R8
      ind_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (spi_wr_i.en && ind_wr_i.en && ind_wr_i.addr == ADDR_W'(i)
          && spi_wr_i.addr != ADDR_W'(i)) |=> $stable(q[i]));
   end

   always_comb begin
      spi_rdata_o = '0;
      ind_rdata_o = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (spi_raddr_i == ADDR_W'(k)) spi_rdata_o = q[k];
         if (ind_raddr_i == ADDR_W'(k)) ind_rdata_o = q[k];
      end
   end
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
   import spi_cfg_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int NUM_REGS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_cs_n,
   input  logic                       spi_sclk,
   input  logic                       spi_sdi,
   output logic                       spi_sdo,
   input  logic                       ind_we,
   input  logic [ADDR_W-1:0]          ind_addr,
   input  logic [DATA_W-1:0]          ind_wdata,
   output logic [DATA_W-1:0]          ind_rdata,
   output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
   if (ADDR_W != ADR_W || DATA_W != WORD_W) begin : g_bad_pkg
      $error("spi_cfg_bank: widths must match the register package");
   end

   logic cs_lvl, cs_r_unused, cs_f_unused;
   logic sck_lvl_unused, sck_rise, sck_fall;
   logic sdi_lvl, sdi_r_unused, sdi_f_unused;

   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .pin_i(spi_cs_n),
      .level_o(cs_lvl), .rise_o(cs_r_unused), .fall_o(cs_f_unused));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_sck (
      .clk(clk), .rst_n(rst_n), .pin_i(spi_sclk),
      .level_o(sck_lvl_unused), .rise_o(sck_rise), .fall_o(sck_fall));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_sdi (
      .clk(clk), .rst_n(rst_n), .pin_i(spi_sdi),
      .level_o(sdi_lvl), .rise_o(sdi_r_unused), .fall_o(sdi_f_unused));

   logic [ADDR_W-1:0] spi_raddr, spi_waddr;
   logic [DATA_W-1:0] spi_rdata, spi_wdata, ind_raw;
   logic              spi_we;
   wr_req_t           spi_req, ind_req;

   spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .sel_i(!cs_lvl),
      .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sdi_i(sdi_lvl),
      .rd_data_i(spi_rdata), .rd_addr_o(spi_raddr),
      .wr_en_o(spi_we), .wr_addr_o(spi_waddr), .wr_data_o(spi_wdata),
      .sdo_o(spi_sdo));

   assign spi_req = '{en: spi_we,  addr: spi_waddr, data: spi_wdata};
   assign ind_req = '{en: ind_we,  addr: ind_addr,  data: ind_wdata};

   cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .spi_wr_i(spi_req), .spi_raddr_i(spi_raddr), .spi_rdata_o(spi_rdata),
      .ind_wr_i(ind_req), .ind_raddr_i(ind_addr), .ind_rdata_o(ind_raw),
      .regs_o(cfg_regs));

   assign ind_rdata = cfg_regs[IND_RD_BIT] ? ind_raw : '0;
endmodule

// File: tb/test_spi_cfg_bank.sv
module test_spi_cfg_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   // {addr, write data, expected read-back}
   localparam logic [38:0] VEC [NV] = '{
      {7'h00, 16'hFFFF, 16'h3FFF},
      {7'h01, 16'hA5C3, 16'hA5C3},
      {7'h0C, 16'hFFFF, 16'h01FF},
      {7'h0D, 16'h1234, 16'h1234},
      {7'h1A, 16'hFFFF, 16'h0FFF},
      {7'h05, 16'hBEEF, 16'h0000},
      {7'h40, 16'hFFFF, 16'h0000},
      {7'h17, 16'h8001, 16'h8001}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0, spi_sdo;
   logic ind_we = 1'b0;
   logic [6:0] ind_addr = '0;
   logic [15:0] ind_wdata = '0, ind_rdata;
   logic [511:0] cfg_regs;
   int checks = 0, errors = 0;
   logic [6:0] va;
   logic [15:0] vw, ve, rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cfg_bank i_spi_cfg_bank (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .ind_we(ind_we), .ind_addr(ind_addr),
      .ind_wdata(ind_wdata), .ind_rdata(ind_rdata), .cfg_regs(cfg_regs));

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] reg_of(input int n);
      return cfg_regs[n*16 +: 16];
   endfunction

   // hit: fire a parallel write to 0x13 in the serial commit cycle
   task automatic spi_xfer(input logic rd_n_wr, input logic [6:0] a, input logic [15:0] wd,
                           input int nbits, input logic hit, output logic [15:0] rdat);
      logic [23:0] f;
      f = {a, rd_n_wr, wd};
      rdat = '0;
      spi_cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_sdi  = f[23-i];
         spi_sclk = 1'b1;
         repeat (4) @(negedge clk);
         if (i >= 8) rdat = {rdat[14:0], spi_sdo};
         spi_sclk = 1'b0;
         if (hit && i == 23) begin
            @(posedge clk); @(posedge clk); @(posedge clk);
            @(negedge clk);
            ind_we = 1'b1; ind_addr = 7'h13; ind_wdata = 16'h3333;
            @(negedge clk);
            ind_we = 1'b0;
            repeat (2) @(negedge clk);
         end else begin
            repeat (4) @(negedge clk);
         end
      end
      repeat (4) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset values, R9 parallel layout
      check("R1 reg00", reg_of('h00), 16'h0004);
      check("R1 reg01", reg_of('h01), 16'h282B);
      check("R1 reg0C", reg_of('h0C), 16'h00ED);
      check("R9 reg0D", reg_of('h0D), 16'h0825);
      check("R1 reg1A", reg_of('h1A), 16'h05C6);
      check("R1 sdo idle", {15'd0, spi_sdo}, 16'h0000);
      // R4 serial read of a reset value
      spi_xfer(1'b1, 7'h01, 16'h0000, 24, 1'b0, rd);
      check("R4 read reg01", rd, 16'h282B);

      // R2 R3 R5 table of write then read-back
      for (int k = 0; k < NV; k++) begin
         va = VEC[k][38:32]; vw = VEC[k][31:16]; ve = VEC[k][15:0];
         spi_xfer(1'b0, va, vw, 24, 1'b0, rd);
         spi_xfer(1'b1, va, 16'h0000, 24, 1'b0, rd);
         check("R2/R3/R5 read-back", rd, ve);
         if (va < 7'd32) check("R9 parallel copy", reg_of(int'(va)), ve);
      end

      // R6 truncated frame is discarded
      spi_xfer(1'b0, 7'h0D, 16'h5555, 20, 1'b0, rd);
      check("R6 parallel after short frame", reg_of('h0D), 16'h1234);
      spi_xfer(1'b1, 7'h0D, 16'h0000, 24, 1'b0, rd);
      check("R6 read after short frame", rd, 16'h1234);

      // R7 parallel read gated by bit 12 of reg 0x00 (set by table)
      ind_addr = 7'h0D;
      @(negedge clk);
      check("R7 gated read open", ind_rdata, 16'h1234);
      spi_xfer(1'b0, 7'h00, 16'h0000, 24, 1'b0, rd);
      ind_addr = 7'h0D;
      @(negedge clk);
      check("R7 gated read closed", ind_rdata, 16'h0000);
      ind_we = 1'b1; ind_addr = 7'h13; ind_wdata = 16'h7777;
      @(negedge clk);
      ind_we = 1'b0;
      @(negedge clk);
      check("R7 parallel write", reg_of('h13), 16'h7777);
      ind_we = 1'b1; ind_addr = 7'h0C; ind_wdata = 16'hFFFF;
      @(negedge clk);
      ind_we = 1'b0;
      @(negedge clk);
      check("R7 parallel write masked", reg_of('h0C), 16'h01FF);
      spi_xfer(1'b1, 7'h13, 16'h0000, 24, 1'b0, rd);
      check("R7 serial sees parallel write", rd, 16'h7777);

      // R8 simultaneous writes: serial wins
      spi_xfer(1'b0, 7'h13, 16'h00AA, 24, 1'b1, rd);
      check("R8 serial wins", reg_of('h13), 16'h00AA);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule